// File: doc/BRIEF.md
# Serial Flash Read-Fetch Sequencer

This block turns one fetch request from a memory-mapped read port into one complete read transaction on a serial flash bus. A transaction is a sequence of phases: an 8-bit opcode, a 24- or 32-bit address, an optional run of mode clocks and then a data phase in which a requested number of bytes is shifted in. The opcode, address and data phases each move 1, 2 or 4 bits per serial clock, chosen independently. An optional opcode-less setting starts the transaction directly with the address, which suits a flash that stays in a continuous-read state.

The serial clock and the select line are made by a separate timing unit. That unit gives the sequencer a one-cycle `tick` for each serial clock and a `winOpen` level while the transaction window is open. The sequencer moves one serial clock forward only when both are high. It drives the data lines and their enables, gathers the returned bytes into a little-endian word and gives a one-cycle done pulse. It also reports how many returned clocks a feedback-sampling front end must discard before data arrives.

Top module: `xipReadSeq`

## Requirements
- R1: After reset `xferActive`, `rspDone` and `ioOe` are low.
- R2: Unless opcode-less mode is set, the first phase shifts out the 8-bit opcode MSB-first. It takes 8, 4 or 2 serial clocks for single, dual or quad width.
- R3: Width code 2'b00 is single, 2'b01 is dual, and 2'b10 or 2'b11 is quad. Single drives line 0 and samples line 1. Dual uses lines 1:0 and quad uses lines 3:0, with the more significant bits on the higher line. While driving, `ioOe` is 4'b0001, 4'b0011 or 4'b1111 and unused lines of `ioOut` are 0.
- R4: The address phase sends the low 24 bits of `reqAddr`, or all 32 bits when `cfgAddr4` is 1, MSB-first. It takes the bit count divided by the address width in clocks.
- R5: After the address come `cfgModeClks` clocks at the address width with the enables on. They carry `cfgModeBits` MSB-first and then zeros. When `cfgModeClks` is 0 there is no mode phase.
- R6: With `cfgNoCmd` set, the opcode phase is left out and the transaction opens with the address phase.
- R7: The data phase holds `ioOe` at 0 for `reqLen`*8 divided by the data width in clocks, capturing the lines on each of those clocks. `reqLen` is 1 to 8.
- R8: `rspData` byte k holds the k-th returned byte for k below `reqLen`; higher bytes are 0. `rspDone` pulses for one cycle on the cycle in which `xferActive` falls.
- R9: `ignoreClks` equals opcode clocks (0 in opcode-less mode) plus address clocks plus `cfgModeClks` for the configuration in use.
- R10: The sequencer advances only on cycles with `tick` and `winOpen` both high. On all other cycles `ioOut`, `ioOe` and `xferActive` hold.
- R11: Configuration inputs are taken only while idle. A change made during a transaction has no effect on that transaction.
- R12: `reqValid` during a transaction is ignored and starts no second transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One pulse per serial clock from the timing unit |
| winOpen | input | 1 | Transaction window open |
| reqValid | input | 1 | Fetch request, taken while idle |
| reqAddr | input | 32 | Byte address of the fetch |
| reqLen | input | 4 | Byte count, 1 to 8 |
| cfgCmd | input | 8 | Read opcode |
| cfgCmdWidth | input | 2 | Opcode phase width code |
| cfgAddrWidth | input | 2 | Address and mode phase width code |
| cfgDataWidth | input | 2 | Data phase width code |
| cfgAddr4 | input | 1 | 32-bit address when 1 |
| cfgNoCmd | input | 1 | Leave out the opcode phase |
| cfgModeClks | input | 4 | Number of mode clocks |
| cfgModeBits | input | 8 | Value driven during mode clocks |
| ioIn | input | 4 | Data lines from the flash |
| ioOut | output | 4 | Data lines to the flash |
| ioOe | output | 4 | Per-line output enable |
| xferActive | output | 1 | Transaction in progress |
| rspDone | output | 1 | One-cycle completion pulse |
| rspData | output | 64 | Returned bytes, little-endian |
| ignoreClks | output | 8 | Returned clocks to discard in feedback sampling |

## Verification
The bench acts as the flash. It logs every driven clock and supplies a known byte stream, and on single width it puts the inverse bit on line 0 so that a design reading the wrong line returns inverted data. The vectors cover every width mix, code 2'b11, a 32-bit address, opcode-less mode, a zero-length mode phase and a 15-clock quad mode run that goes past the 8 mode bits. A wrong clock divisor shows up as a wrong logged clock count, and a missing zero fill shows up as stale address bits on the lines. A byte-order slip shows up as a reversed `rspData`, and a short response that is not masked leaves non-zero high bytes. Further tests close the window in the middle of the opcode, where a design that ignores `winOpen` would keep shifting. They also change every configuration input and raise `reqValid` during a transaction, which a design that samples too late would obey.

// File: rtl/xipSeqPkg.sv
package xipSeqPkg;
  localparam int ADDR_W   = 32;
  localparam int LANES    = 4;
  localparam int MAX_BYTES = 8;
  localparam int LEN_W    = $clog2(MAX_BYTES + 1);
  localparam int DATA_W   = MAX_BYTES * 8;
  localparam int SHIFT_W  = ADDR_W;
  localparam int CNT_W    = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_MODE, PH_DATA
  } phase_e;

  typedef struct packed {
    logic [7:0] cmd;
    logic [1:0] cmdW;
    logic [1:0] addrW;
    logic [1:0] dataW;
    logic       addr4;
    logic       noCmd;
    logic [3:0] modeClks;
    logic [7:0] modeBits;
  } seqCfg_t;

  typedef struct packed {
    logic       load;
    phase_e     loadPh;
    logic       shift;
    logic       capture;
    logic       clear;
    logic       latchAddr;
    logic       drive;
    logic [1:0] laneW;
  } seqStrobe_t;

  // log2 of lines per clock: 0 single, 1 dual, 2 quad
  function automatic logic [1:0] laneLog(logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/xipSeqCtl.sv
module xipSeqCtl
  import xipSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              step,
  input  logic              reqValid,
  input  logic [LEN_W-1:0]  reqLen,
  input  seqCfg_t           cfgIn,
  output seqStrobe_t        strobe,
  output logic [7:0]        effCmd,
  output logic              effAddr4,
  output logic [7:0]        effModeBits,
  output logic [LEN_W-1:0]  lenQ,
  output logic              busy,
  output logic              done,
  output logic [7:0]        ignoreClks
);
  phase_e            ph, nxtPh, tgt;
  seqCfg_t           cfgQ, cfgEff;
  logic [CNT_W-1:0]  cnt, nxtCnt;
  logic [LEN_W-1:0]  lenEff;
  logic              goNext, finish;

  function automatic logic [CNT_W-1:0] phaseClocks(phase_e p, seqCfg_t c, logic [LEN_W-1:0] len);
    logic [CNT_W-1:0] bits;
    case (p)
      PH_CMD:  return CNT_W'(8) >> laneLog(c.cmdW);
      PH_ADDR: begin
        bits = c.addr4 ? CNT_W'(32) : CNT_W'(24);
        return bits >> laneLog(c.addrW);
      end
      PH_MODE: return CNT_W'(c.modeClks);
      PH_DATA: return CNT_W'({len, 3'b000}) >> laneLog(c.dataW);
      default: return CNT_W'(1);
    endcase
  endfunction

  assign cfgEff      = (ph == PH_IDLE) ? cfgIn : cfgQ;
  assign lenEff      = (ph == PH_IDLE) ? reqLen : lenQ;
  assign effCmd      = cfgEff.cmd;
  assign effAddr4    = cfgEff.addr4;
  assign effModeBits = cfgEff.modeBits;
  assign busy        = (ph != PH_IDLE);

  assign ignoreClks = (cfgQ.noCmd ? 8'd0 : 8'(8 >> laneLog(cfgQ.cmdW)))
                    + 8'((cfgQ.addr4 ? 32 : 24) >> laneLog(cfgQ.addrW))
                    + 8'(cfgQ.modeClks);

  always_comb begin
    strobe       = '0;
    strobe.drive = (ph == PH_CMD) || (ph == PH_ADDR) || (ph == PH_MODE);
    case (ph)
      PH_ADDR, PH_MODE: strobe.laneW = cfgQ.addrW;
      PH_DATA:          strobe.laneW = cfgQ.dataW;
      default:          strobe.laneW = cfgQ.cmdW;
    endcase
    nxtPh  = ph;
    nxtCnt = cnt;
    goNext = 1'b0;
    finish = 1'b0;
    tgt    = PH_IDLE;
    if (ph == PH_IDLE) begin
      if (reqValid) begin
        goNext           = 1'b1;
        tgt              = cfgIn.noCmd ? PH_ADDR : PH_CMD;
        strobe.clear     = 1'b1;
        strobe.latchAddr = 1'b1;
      end
    end else if (step) begin
      strobe.capture = (ph == PH_DATA);
      if (cnt != '0) begin
        nxtCnt       = cnt - 1'b1;
        strobe.shift = 1'b1;
      end else begin
        case (ph)
          PH_CMD:  begin goNext = 1'b1; tgt = PH_ADDR; end
          PH_ADDR: begin goNext = 1'b1; tgt = (cfgQ.modeClks != '0) ? PH_MODE : PH_DATA; end
          PH_MODE: begin goNext = 1'b1; tgt = PH_DATA; end
          default: begin nxtPh = PH_IDLE; finish = 1'b1; end
        endcase
      end
    end
    if (goNext) begin
      nxtPh         = tgt;
      strobe.load   = 1'b1;
      strobe.loadPh = tgt;
      nxtCnt        = phaseClocks(tgt, cfgEff, lenEff) - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph   <= PH_IDLE;
      cnt  <= '0;
      cfgQ <= '0;
      lenQ <= '0;
      done <= 1'b0;
    end else begin
      ph   <= nxtPh;
      cnt  <= nxtCnt;
      done <= finish;
      if (ph == PH_IDLE) cfgQ <= cfgIn;
      if (ph == PH_IDLE && reqValid) lenQ <= reqLen;
    end
  end
endmodule

// File: rtl/xipSeqDp.sv
module xipSeqDp
  import xipSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [7:0]        effCmd,
  input  logic              effAddr4,
  input  logic [7:0]        effModeBits,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  lenQ,
  input  logic [LANES-1:0]  ioIn,
  output logic [LANES-1:0]  ioOut,
  output logic [LANES-1:0]  ioOe,
  output logic [DATA_W-1:0] rspData
);
  logic [SHIFT_W-1:0] sr;
  logic [ADDR_W-1:0]  addrQ, addrSrc;
  logic [DATA_W-1:0]  acc;
  logic [LANES-1:0]   inBits;
  logic [1:0]         lg;

  assign lg      = laneLog(strobe.laneW);
  assign addrSrc = strobe.latchAddr ? reqAddr : addrQ;

  always_comb begin
    case (lg)
      2'd0:    inBits = {3'b000, ioIn[1]};
      2'd1:    inBits = {2'b00, ioIn[1:0]};
      default: inBits = ioIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sr    <= '0;
      addrQ <= '0;
      acc   <= '0;
    end else begin
      if (strobe.latchAddr) addrQ <= reqAddr;
      if (strobe.load) begin
        case (strobe.loadPh)
          PH_CMD:  sr <= {effCmd, (SHIFT_W-8)'(0)};
          PH_ADDR: sr <= effAddr4 ? addrSrc : {addrSrc[23:0], 8'h00};
          PH_MODE: sr <= {effModeBits, (SHIFT_W-8)'(0)};
          default: sr <= '0;
        endcase
      end else if (strobe.shift) begin
        sr <= sr << (1 << lg);
      end
      if (strobe.clear)        acc <= '0;
      else if (strobe.capture) acc <= (acc << (1 << lg)) | DATA_W'(inBits);
    end
  end

  always_comb begin
    ioOut = '0;
    ioOe  = '0;
    if (strobe.drive) begin
      case (lg)
        2'd0:    begin ioOut = {3'b000, sr[SHIFT_W-1]};      ioOe = 4'b0001; end
        2'd1:    begin ioOut = {2'b00, sr[SHIFT_W-1 -: 2]};  ioOe = 4'b0011; end
        default: begin ioOut = sr[SHIFT_W-1 -: 4];           ioOe = 4'b1111; end
      endcase
    end
  end

  // first byte received sits highest in acc; place it in byte 0
  always_comb begin
    rspData = '0;
    for (int k = 0; k < MAX_BYTES; k++) begin
      if (k < int'(lenQ)) rspData[8*k +: 8] = acc[8*(int'(lenQ) - 1 - k) +: 8];
    end
  end
endmodule

// File: rtl/xipReadSeq.sv
module xipReadSeq
  import xipSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              winOpen,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [7:0]        cfgCmd,
  input  logic [1:0]        cfgCmdWidth,
  input  logic [1:0]        cfgAddrWidth,
  input  logic [1:0]        cfgDataWidth,
  input  logic              cfgAddr4,
  input  logic              cfgNoCmd,
  input  logic [3:0]        cfgModeClks,
  input  logic [7:0]        cfgModeBits,
  input  logic [LANES-1:0]  ioIn,
  output logic [LANES-1:0]  ioOut,
  output logic [LANES-1:0]  ioOe,
  output logic              xferActive,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspData,
  output logic [7:0]        ignoreClks
);
  seqCfg_t          cfgIn;
  seqStrobe_t       strobe;
  logic [7:0]       effCmd, effModeBits;
  logic             effAddr4;
  logic [LEN_W-1:0] lenQ;

  assign cfgIn = '{cmd: cfgCmd, cmdW: cfgCmdWidth, addrW: cfgAddrWidth,
                   dataW: cfgDataWidth, addr4: cfgAddr4, noCmd: cfgNoCmd,
                   modeClks: cfgModeClks, modeBits: cfgModeBits};

  xipSeqCtl u_ctl (
    .clk(clk), .rstN(rstN), .step(tick && winOpen), .reqValid(reqValid),
    .reqLen(reqLen), .cfgIn(cfgIn), .strobe(strobe), .effCmd(effCmd),
    .effAddr4(effAddr4), .effModeBits(effModeBits), .lenQ(lenQ),
    .busy(xferActive), .done(rspDone), .ignoreClks(ignoreClks)
  );

  xipSeqDp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .effCmd(effCmd),
    .effAddr4(effAddr4), .effModeBits(effModeBits), .reqAddr(reqAddr),
    .lenQ(lenQ), .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe), .rspData(rspData)
  );
endmodule

// File: rtl/xipReadSeqChk.sv
module xipReadSeqChk (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic       winOpen,
  input logic       reqValid,
  input logic [3:0] ioOut,
  input logic [3:0] ioOe,
  input logic       xferActive,
  input logic       rspDone,
  input logic [7:0] ignoreClks
);
  // R3
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe == 4'b0000) || (ioOe == 4'b0001) || (ioOe == 4'b0011) || (ioOe == 4'b1111));

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xferActive |-> (ioOe == 4'b0000) && (ioOut == 4'b0000));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferActive && !(tick && winOpen)) |=> xferActive && $stable(ioOut) && $stable(ioOe));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspDone) |-> $fell(xferActive));

  // R12
  no_spurious_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!xferActive && !reqValid) |=> !xferActive);

  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferActive |=> (!xferActive || $stable(ignoreClks)));
endmodule

bind xipReadSeq xipReadSeqChk u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .winOpen(winOpen), .reqValid(reqValid),
  .ioOut(ioOut), .ioOe(ioOe), .xferActive(xferActive), .rspDone(rspDone),
  .ignoreClks(ignoreClks)
);

// File: tb/xipReadSeq_bench.sv
`timescale 1ns/1ps
module xipReadSeq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0, winOpen = 1'b0, reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqLen = '0;
  logic [7:0]  cfgCmd = '0, cfgModeBits = '0;
  logic [1:0]  cfgCmdWidth = '0, cfgAddrWidth = '0, cfgDataWidth = '0;
  logic        cfgAddr4 = 1'b0, cfgNoCmd = 1'b0;
  logic [3:0]  cfgModeClks = '0;
  logic [3:0]  ioIn = '0;
  logic [3:0]  ioOut, ioOe;
  logic        xferActive, rspDone;
  logic [63:0] rspData;
  logic [7:0]  ignoreClks;

  always #2.5 clk = ~clk;

  xipReadSeq u_xipReadSeq (.*);

  int nChecks = 0, nFails = 0;
  bit summaryDone = 0;

  // vector: cmdW aw dw a4 nc modeClks len cmd mode addr
  localparam logic [63:0] VECS [8] = '{
    {2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0,  4'd4, 8'h03, 8'h00, 32'h00123456},
    {2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 4'd8,  4'd8, 8'h3B, 8'h00, 32'h00ABCDEF},
    {2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 4'd6,  4'd8, 8'hEB, 8'hA0, 32'h00102030},
    {2'd2, 2'd2, 2'd2, 1'b1, 1'b0, 4'd4,  4'd3, 8'hEC, 8'hF5, 32'h89ABCDEF},
    {2'd0, 2'd2, 2'd2, 1'b0, 1'b1, 4'd6,  4'd2, 8'hEB, 8'h20, 32'h00FF00AA},
    {2'd1, 2'd1, 2'd1, 1'b1, 1'b0, 4'd2,  4'd1, 8'hBB, 8'h5A, 32'h12345678},
    {2'd0, 2'd1, 2'd2, 1'b0, 1'b0, 4'd0,  4'd5, 8'h6B, 8'h00, 32'h00C0FFEE},
    {2'd0, 2'd3, 2'd0, 1'b0, 1'b1, 4'd15, 4'd7, 8'h00, 8'hC3, 32'h00777777}
  };

  // flash model state
  bit          hold = 0, tickPh = 0;
  int          outCnt = 0, inCnt = 0;
  logic [3:0]  logOut [128];
  logic [3:0]  logOe  [128];
  logic [1:0]  curDw = 0;
  logic [31:0] curAddr = 0;

  // expected stream
  logic [3:0]  expOut [128];
  logic [3:0]  expOe  [128];
  int          expN = 0;

  function automatic int lgOf(logic [1:0] c);
    return (c == 2'd0) ? 0 : (c == 2'd1) ? 1 : 2;
  endfunction

  function automatic logic [7:0] flashByte(int j);
    return (curAddr[7:0] + 8'(j * 37)) ^ 8'h5A;
  endfunction

  function automatic logic [3:0] dataChunk(int i);
    int lw = lgOf(curDw);
    int w = 1 << lw;
    int per = 8 / w;
    logic [7:0] b = flashByte(i / per);
    int sh = 8 - ((i % per) + 1) * w;
    logic [3:0] val = 4'((b >> sh) & ((1 << w) - 1));
    case (lw)
      0:       return {2'b00, val[0], ~val[0]};
      1:       return {2'b10, val[1:0]};
      default: return val;
    endcase
  endfunction

  always @(negedge clk) begin
    tickPh  = !tickPh;
    tick    = tickPh;
    winOpen = xferActive && !hold;
    if (tick && winOpen) begin
      if (ioOe != 4'b0000) begin
        if (outCnt < 128) begin logOut[outCnt] = ioOut; logOe[outCnt] = ioOe; end
        outCnt++;
      end else begin
        ioIn = dataChunk(inCnt);
        inCnt++;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic pushChunks(logic [63:0] v, int bits, int w, int n);
    for (int i = 0; i < n; i++) begin
      int sh = bits - w * (i + 1);
      expOut[expN] = (sh >= 0) ? 4'((v >> sh) & ((1 << w) - 1)) : 4'h0;
      expOe[expN]  = 4'((1 << w) - 1);
      expN++;
    end
  endtask

  task automatic finishSummary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // mode 0 plain, 1 close window mid-run, 2 disturb config and request mid-run
  task automatic runVec(logic [63:0] v, int mode, string name);
    logic [1:0] cw = v[63:62], aw = v[61:60], dw = v[59:58];
    logic a4 = v[57], nc = v[56];
    logic [3:0] mc = v[55:52], len = v[51:48];
    logic [7:0] cmd = v[47:40], mb = v[39:32];
    logic [31:0] addr = v[31:0];
    int wa = 1 << lgOf(aw), wc = 1 << lgOf(cw), wd = 1 << lgOf(dw);
    int ab = a4 ? 32 : 24;
    int expIgn = (nc ? 0 : 8 / wc) + ab / wa + int'(mc);
    int wait_n = 0, bad = 0;
    bit acted = 0;
    logic [63:0] expData = '0;

    expN = 0;
    if (!nc) pushChunks(64'(cmd), 8, wc, 8 / wc);
    pushChunks(a4 ? 64'(addr) : 64'(addr[23:0]), ab, wa, ab / wa);
    pushChunks({mb, 56'h0}, 64, wa, int'(mc));

    @(negedge clk);
    cfgCmd = cmd; cfgCmdWidth = cw; cfgAddrWidth = aw; cfgDataWidth = dw;
    cfgAddr4 = a4; cfgNoCmd = nc; cfgModeClks = mc; cfgModeBits = mb;
    curDw = dw; curAddr = addr; outCnt = 0; inCnt = 0;
    reqAddr = addr; reqLen = len; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;

    while (!rspDone && wait_n < 3000) begin
      if (!acted && outCnt >= 5 && mode == 1) begin
        logic [3:0] o1, e1;
        acted = 1;
        hold = 1;
        repeat (2) @(negedge clk);
        o1 = ioOut; e1 = ioOe;
        repeat (20) @(negedge clk);
        chk(ioOut == o1 && ioOe == e1 && xferActive && outCnt < expN, {"R10 window closed hold ", name},
            {ioOe, ioOut}, {e1, o1});
        hold = 0;
      end
      if (!acted && outCnt >= 6 && mode == 2) begin
        acted = 1;
        cfgCmd = ~cmd; cfgCmdWidth = 2'd2; cfgAddrWidth = 2'd0; cfgDataWidth = 2'd1;
        cfgAddr4 = !a4; cfgNoCmd = !nc; cfgModeClks = 4'd9; cfgModeBits = ~mb;
        reqValid = 1'b1; reqAddr = 32'hDEAD0000; reqLen = 4'd2;
        @(negedge clk);
        reqValid = 1'b0;
      end
      @(negedge clk);
      wait_n++;
    end
    chk(rspDone, {"R8 done seen ", name}, 64'(rspDone), 64'd1);

    for (int k = 0; k < int'(len); k++) expData[8*k +: 8] = flashByte(k);
    chk(outCnt == expN, {"R2/R4/R5/R6 driven clock count ", name}, 64'(outCnt), 64'(expN));
    for (int i = 0; i < expN && i < outCnt && i < 128; i++)
      if (logOut[i] !== expOut[i] || logOe[i] !== expOe[i]) bad++;
    chk(bad == 0, {"R3 driven lines and enables ", name}, 64'(bad), 64'd0);
    chk(inCnt == int'(len) * 8 / wd, {"R7 data clocks ", name}, 64'(inCnt), 64'(int'(len) * 8 / wd));
    chk(rspData === expData, {"R8 response word ", name}, rspData, expData);
    chk(ignoreClks == 8'(expIgn), {"R9 ignore count ", name}, 64'(ignoreClks), 64'(expIgn));
    @(negedge clk);
    chk(!rspDone && !xferActive, {"R8 single pulse ", name}, {62'd0, rspDone, xferActive}, 64'd0);
    if (mode == 2) begin
      repeat (10) @(negedge clk);
      chk(!xferActive, "R12 busy request ignored", 64'(xferActive), 64'd0);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    nFails++;
    $display("FAIL R8 watchdog expired act=0 exp=1");
    finishSummary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!xferActive && !rspDone && ioOe == 4'b0000, "R1 state in reset",
        {58'd0, xferActive, rspDone, ioOe}, 64'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!xferActive && !rspDone && ioOe == 4'b0000, "R1 state after reset",
        {58'd0, xferActive, rspDone, ioOe}, 64'd0);

    for (int n = 0; n < 8; n++) runVec(VECS[n], 0, $sformatf("vec%0d", n));

    // R10: window closed during the opcode phase
    runVec(VECS[0], 1, "hold");
    // R11 and R12: config and request disturbed during transaction
    runVec(VECS[2], 2, "disturb");
    // R6: opcode-less with single address width
    runVec({2'd1, 2'd0, 2'd1, 1'b1, 1'b1, 4'd0, 4'd6, 8'h11, 8'h00, 32'hA5A5F00D}, 0, "nocmd_single");

    finishSummary();
  end
endmodule